// File: doc/BRIEF.md
# I2C Bus State Monitor with Arbitration Detection

This block watches the synchronized SDA and SCL levels of a two-wire bus on behalf of one bus master. While the master function is enabled it classifies the bus into one of four states: unknown, idle, busy, or owned by this master. It detects START and STOP conditions and counts SCL rising edges within each nine-bit slot. When SCL has stayed high with no line activity for a programmed number of clock cycles, it returns a stalled bus to idle.

While this master owns the bus, the block compares the level the master drives on SDA with the level on the line. A released (high) drive that reads back low means another master has won arbitration. In that case the state falls back to busy and a sticky flag is raised. A START seen during ownership that this master did not issue cannot be resolved by the hardware. It sets a separate sticky flag so that software can handle it. Byte assembly and register access belong to the surrounding controller.

Top module: `i2c_bus_watch`

## Requirements
- R1: While `enable` is low, and on the clock edge after reset, `bus_state` is unknown (00), `bit_cnt` is 0, and all three sticky flags are 0. Line activity while disabled has no effect on these outputs.
- R2: The state encoding is unknown = 00, idle = 01, owner = 10, busy = 11. A START is SDA falling while SCL is high in both the previous and the current sample. A STOP is SDA rising under the same SCL condition. Outputs change on the clock edge that samples the condition.
- R3: A STOP moves the state to idle from any state.
- R4: A START with `start_issue` low moves the state to busy. A START with `start_issue` high moves the state to owner if the state was idle, keeps it at owner if the state was owner (repeated START), and moves it to busy otherwise.
- R5: In the owner state, an SCL rising edge with `sda_drive` = 1 and `sda_in` = 0 moves the state to busy and sets `arb_lost`. When the drive and line levels agree, ownership is kept and the flag is unchanged.
- R6: In the owner state, a START with `start_issue` low sets `start_clash` and moves the state to busy.
- R7: If the state is not idle and SCL stays high with neither line changing for `idle_limit` consecutive clock cycles, the state becomes idle and `timed_out` is set. Any change on either line restarts the count. An `idle_limit` of 0 disables the timeout.
- R8: `bit_cnt` clears on START or STOP. It increments on each SCL rising edge while the state is busy or owner, and wraps to 0 on the ninth rising edge, so its range is 0 to 8.
- R9: `arb_lost`, `timed_out` and `start_clash` stay set until a cycle with `clear_flags` high clears them. A new set in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Master function enabled; monitoring runs while high |
| sda_in | input | 1 | Synchronized SDA line level |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_drive | input | 1 | Level this master drives on SDA (1 = released) |
| start_issue | input | 1 | High while this master is issuing a START |
| idle_limit | input | TIMER_W | Inactive-bus timeout in clock cycles (0 = off) |
| clear_flags | input | 1 | Clears the sticky flags |
| bus_state | output | 2 | Bus state code |
| bit_cnt | output | CNT_W | SCL rising edges since the last START, modulo 9 |
| arb_lost | output | 1 | Sticky: arbitration was lost |
| timed_out | output | 1 | Sticky: inactive-bus timeout forced idle |
| start_clash | output | 1 | Sticky: a START from another device arrived during ownership |

## Verification
On every cycle, the assertions check the following:
- A disabled block reports unknown with its flags clear.
- A STOP always yields idle, and a START issued from idle yields ownership.
- An owner that reads low while releasing SDA on an SCL rise loses to busy with `arb_lost` set, and that flag holds until cleared.
- The bit counter never leaves 0 to 8 and wraps after its ninth edge.
- The timeout counter restarts after it fires.

Only the bench scenarios show the following:
- The exact cycle on which a stalled bus times out.
- That an `idle_limit` of 0 keeps a stalled bus busy.
- That drive and line levels that agree leave ownership intact.
- That a repeated START issued by the owner keeps ownership.
- That a foreign START during ownership raises `start_clash`.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [1:0] {
        BUS_UNKNOWN = 2'b00,
        BUS_IDLE    = 2'b01,
        BUS_OWNER   = 2'b10,
        BUS_BUSY    = 2'b11
    } bus_state_e;

    typedef struct packed {
        bus_state_e state;
        logic       arb_lost;
        logic       timed_out;
        logic       clash;
    } ctl_t;

    typedef struct packed {
        logic sda_p;
        logic scl_p;
        logic primed;
    } edge_t;

endpackage

// File: rtl/i2cw_line_edges.sv
module i2cw_line_edges
    import i2cw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sda_in,
    input  logic scl_in,
    output logic start_seen,
    output logic stop_seen,
    output logic scl_rise,
    output logic quiet
);

    edge_t e_d, e_q;
    logic  live;

    always_comb begin
        e_d        = e_q;
        e_d.sda_p  = sda_in;
        e_d.scl_p  = scl_in;
        e_d.primed = enable;

        live       = enable & e_q.primed;
        start_seen = live & e_q.scl_p & scl_in & e_q.sda_p & ~sda_in;
        stop_seen  = live & e_q.scl_p & scl_in & ~e_q.sda_p & sda_in;
        scl_rise   = live & ~e_q.scl_p & scl_in;
        quiet      = live & e_q.scl_p & scl_in & (e_q.sda_p == sda_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{sda_p: 1'b1, scl_p: 1'b1, primed: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

endmodule

// File: rtl/i2cw_quiet_timer.sv
module i2cw_quiet_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               quiet,
    input  logic [TIMER_W-1:0] limit,
    output logic               expire
);

    localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

    logic [TIMER_W-1:0] count_d, count_q;

    always_comb begin
        expire  = run & quiet & (limit != '0) & (count_q == limit - ONE);
        count_d = count_q;
        if (!run || !quiet || limit == '0 || expire) begin
            count_d = '0;
        end else begin
            count_d = count_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // R7: after the timeout fires, the count starts again from zero
    a_r7_restart_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count_q == '0);

    // R7: any line activity or SCL low restarts the count
    a_r7_activity_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> count_q == '0);

endmodule

// File: rtl/i2cw_bit_counter.sv
module i2cw_bit_counter #(
    parameter int SLOT_BITS = 9,
    localparam int CNT_W    = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             frame_reset,
    input  logic             rise,
    input  logic             active,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_BITS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable || frame_reset) begin
            cnt_d = '0;
        end else if (rise && active) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R8: the count stays inside one slot
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < SLOT_BITS);

    // R8: the ninth rising edge wraps the count
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !frame_reset && rise && active && cnt_q == LAST |=> cnt_q == '0);

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2cw_pkg::*;
#(
    parameter int TIMER_W   = 16,
    parameter int SLOT_BITS = 9,
    localparam int CNT_W    = $clog2(SLOT_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sda_in,
    input  logic               scl_in,
    input  logic               sda_drive,
    input  logic               start_issue,
    input  logic [TIMER_W-1:0] idle_limit,
    input  logic               clear_flags,
    output logic [1:0]         bus_state,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               arb_lost,
    output logic               timed_out,
    output logic               start_clash
);

    ctl_t ctl_d, ctl_q;
    logic start_seen, stop_seen, scl_rise, quiet, expire;
    logic lost_now, timer_run, count_active;

    i2cw_line_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sda_in     (sda_in),
        .scl_in     (scl_in),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .scl_rise   (scl_rise),
        .quiet      (quiet)
    );

    assign timer_run = enable && (ctl_q.state != BUS_IDLE);

    i2cw_quiet_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .quiet  (quiet),
        .limit  (idle_limit),
        .expire (expire)
    );

    assign count_active = (ctl_q.state == BUS_BUSY) || (ctl_q.state == BUS_OWNER);

    i2cw_bit_counter #(.SLOT_BITS(SLOT_BITS)) u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .frame_reset (start_seen | stop_seen),
        .rise        (scl_rise),
        .active      (count_active),
        .cnt         (bit_cnt)
    );

    assign lost_now = (ctl_q.state == BUS_OWNER) && scl_rise && sda_drive && !sda_in;

    always_comb begin
        ctl_d = ctl_q;
        if (!enable) begin
            ctl_d = '{state: BUS_UNKNOWN, arb_lost: 1'b0, timed_out: 1'b0, clash: 1'b0};
        end else begin
            if (clear_flags) begin
                ctl_d.arb_lost  = 1'b0;
                ctl_d.timed_out = 1'b0;
                ctl_d.clash     = 1'b0;
            end
            if (stop_seen) begin
                ctl_d.state = BUS_IDLE;
            end else if (start_seen) begin
                if (start_issue &&
                    (ctl_q.state == BUS_IDLE || ctl_q.state == BUS_OWNER)) begin
                    ctl_d.state = BUS_OWNER;
                end else begin
                    ctl_d.state = BUS_BUSY;
                    if (ctl_q.state == BUS_OWNER) begin
                        ctl_d.clash = 1'b1;
                    end
                end
            end else if (lost_now) begin
                ctl_d.state    = BUS_BUSY;
                ctl_d.arb_lost = 1'b1;
            end else if (expire) begin
                ctl_d.state     = BUS_IDLE;
                ctl_d.timed_out = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: BUS_UNKNOWN, arb_lost: 1'b0, timed_out: 1'b0, clash: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_state   = ctl_q.state;
    assign arb_lost    = ctl_q.arb_lost;
    assign timed_out   = ctl_q.timed_out;
    assign start_clash = ctl_q.clash;

    // R1: a disabled monitor reports unknown with clear flags
    a_r1_disable_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (bus_state == 2'b00) && !arb_lost && !timed_out && !start_clash);

    // R3: STOP always yields idle
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        enable && stop_seen |=> bus_state == 2'b01);

    // R4: own START from idle yields ownership
    a_r4_own_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        enable && start_seen && start_issue && bus_state == 2'b01 |=> bus_state == 2'b10);

    // R5: released drive reading low on an SCL rise loses arbitration
    a_r5_arb_loss: assert property (@(posedge clk) disable iff (!rst_n)
        enable && bus_state == 2'b10 && !start_seen && !stop_seen &&
        scl_rise && sda_drive && !sda_in |=> arb_lost && bus_state == 2'b11);

    // R9: arbitration flag holds until cleared
    a_r9_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enable && arb_lost && !clear_flags |=> arb_lost);

endmodule

// File: tb/test_i2c_bus_watch.sv
`timescale 1ns/1ps
module test_i2c_bus_watch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        sda = 1'b1;
    logic        scl = 1'b1;
    logic        drv = 1'b0;
    logic        st_iss = 1'b0;
    logic [15:0] limit = 16'd1000;
    logic        clr = 1'b0;
    logic [1:0]  state;
    logic [3:0]  cnt;
    logic        arb, tmo, clash;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [1:0] S_UNK = 2'b00, S_IDLE = 2'b01, S_OWN = 2'b10, S_BUSY = 2'b11;

    always #4 clk = ~clk;

    i2c_bus_watch i_i2c_bus_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sda_in      (sda),
        .scl_in      (scl),
        .sda_drive   (drv),
        .start_issue (st_iss),
        .idle_limit  (limit),
        .clear_flags (clr),
        .bus_state   (state),
        .bit_cnt     (cnt),
        .arb_lost    (arb),
        .timed_out   (tmo),
        .start_clash (clash)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic line(input logic s, input logic c);
        @(negedge clk);
        sda = s;
        scl = c;
    endtask

    task automatic settle;
        @(negedge clk);
    endtask

    task automatic stop_cond;
        line(0, 0); line(0, 1); line(1, 1); settle();
    endtask

    task automatic start_cond(input logic mine);
        st_iss = mine;
        line(1, 1); line(1, 1); line(0, 1); settle();
        st_iss = 1'b0;
    endtask

    task automatic clock_bit(input logic b);
        line(b, 0); line(b, 1); settle();
    endtask

    task automatic clear_all;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset state", {6'd0, state}, {6'd0, S_UNK});
        chk("R1 reset flags", {5'd0, arb, tmo, clash}, 8'd0);
        chk("R1 reset count", {4'd0, cnt}, 8'd0);
        enable = 1'b1;
        settle(); settle();
        chk("R1 unknown after enable", {6'd0, state}, {6'd0, S_UNK});
    endtask

    task automatic t_stop_idle;
        stop_cond();
        chk("R3 R2 stop gives idle 01", {6'd0, state}, {6'd0, S_IDLE});
    endtask

    task automatic t_bits;
        start_cond(1'b0);
        chk("R4 foreign start busy 11", {6'd0, state}, {6'd0, S_BUSY});
        chk("R8 count cleared by start", {4'd0, cnt}, 8'd0);
        clock_bit(1);
        chk("R8 first rise", {4'd0, cnt}, 8'd1);
        for (int i = 0; i < 7; i++) clock_bit(i[0]);
        chk("R8 eighth rise", {4'd0, cnt}, 8'd8);
        clock_bit(0);
        chk("R8 ninth rise wraps", {4'd0, cnt}, 8'd0);
        clock_bit(1);
        chk("R8 counts on after wrap", {4'd0, cnt}, 8'd1);
        stop_cond();
        chk("R3 stop from busy", {6'd0, state}, {6'd0, S_IDLE});
        chk("R8 count cleared by stop", {4'd0, cnt}, 8'd0);
    endtask

    task automatic t_own;
        start_cond(1'b1);
        chk("R4 own start from idle", {6'd0, state}, {6'd0, S_OWN});
        clock_bit(1);
        st_iss = 1'b1;
        line(0, 1); settle();
        st_iss = 1'b0;
        chk("R4 repeated own start keeps owner", {6'd0, state}, {6'd0, S_OWN});
        chk("R6 no clash on own repeated start", {7'd0, clash}, 8'd0);
        stop_cond();
        chk("R3 stop from owner", {6'd0, state}, {6'd0, S_IDLE});
    endtask

    task automatic t_arb;
        start_cond(1'b1);
        drv = 1'b1;
        clock_bit(1);
        chk("R5 drive 1 line 1 keeps owner", {6'd0, state}, {6'd0, S_OWN});
        drv = 1'b0;
        clock_bit(0);
        chk("R5 drive 0 line 0 keeps owner", {6'd0, state}, {6'd0, S_OWN});
        chk("R5 no loss when levels agree", {7'd0, arb}, 8'd0);
        drv = 1'b1;
        clock_bit(0);
        chk("R5 loss moves to busy", {6'd0, state}, {6'd0, S_BUSY});
        chk("R5 loss sets flag", {7'd0, arb}, 8'd1);
        drv = 1'b0;
        stop_cond();
        chk("R9 flag sticky across stop", {7'd0, arb}, 8'd1);
        clear_all();
        chk("R9 clear drops flag", {7'd0, arb}, 8'd0);
    endtask

    task automatic t_clash;
        start_cond(1'b1);
        clock_bit(1);
        line(0, 1); settle();
        chk("R6 foreign start in owner gives busy", {6'd0, state}, {6'd0, S_BUSY});
        chk("R6 clash flag set", {7'd0, clash}, 8'd1);
        stop_cond();
        clear_all();
        chk("R9 clash cleared", {7'd0, clash}, 8'd0);
    endtask

    task automatic t_timeout;
        limit = 16'd20;
        start_cond(1'b0);
        repeat (19) settle();
        chk("R7 still busy one cycle before limit", {6'd0, state}, {6'd0, S_BUSY});
        settle();
        chk("R7 timeout forces idle", {6'd0, state}, {6'd0, S_IDLE});
        chk("R7 timeout flag set", {7'd0, tmo}, 8'd1);
        limit = 16'd0;
        start_cond(1'b0);
        repeat (50) settle();
        chk("R7 limit zero keeps busy", {6'd0, state}, {6'd0, S_BUSY});
        chk("R9 timeout flag still set", {7'd0, tmo}, 8'd1);
        limit = 16'd1000;
    endtask

    task automatic t_disable;
        enable = 1'b0;
        settle();
        chk("R1 disable gives unknown", {6'd0, state}, {6'd0, S_UNK});
        chk("R1 disable clears flags", {5'd0, arb, tmo, clash}, 8'd0);
        line(1, 1); line(0, 1); settle();
        chk("R1 start ignored while disabled", {6'd0, state}, {6'd0, S_UNK});
        chk("R1 count held while disabled", {4'd0, cnt}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_stop_idle();
        t_bits();
        t_own();
        t_arb();
        t_clash();
        t_timeout();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule